// File: doc/BRIEF.md
# Variable-Latency Issue Interlock

This block sits at the decode stage of an in-order pipeline whose execution units finish after different numbers of cycles. The units are a single-cycle integer unit, a pipelined three-cycle floating-point adder, a pipelined four-cycle multiplier and a divider that is not pipelined and stays busy for eight cycles. Each cycle the block looks at the decoded instruction (its unit, two source registers and one destination register) and decides whether it may leave decode now or must wait. Instructions leave decode strictly in program order. A held instruction keeps its place and is judged again on the next cycle.

Four hazards hold an instruction back. The first is a divide arriving while the divider is still working. The second is a collision with an earlier instruction at the shared memory/writeback stage. The third is a read of a register whose result is not yet ready to forward. The fourth is a write that would land before an older pending write to the same register. Write-after-read needs no check, because operands are read in decode and written in the final stage. Two structures track in-flight work. A shift ring marks the future memory-stage cycles that are already claimed. A per-register countdown table records how soon each pending result becomes available. The divider's occupancy is a two-state machine. In state DV_IDLE the divider is free. The transition START leads to DV_RUN when a divide leaves decode. The transition DONE returns it to DV_IDLE when its remaining-cycle count reaches one. Every other cycle holds the current state.

Top module: `fu_issue_gate`

## Requirements
- R1: `issue_o` equals `dec_valid_i` and not `stall_o`. `stall_o` is never high while `dec_valid_i` is low. While `dec_valid_i` is high, exactly one of `stall_o` and `issue_o` is high.
- R2: Unit codes on `dec_unit_i` are 0 integer (latency 1), 1 adder (latency 3), 2 multiplier (latency 4) and 3 divider (latency 8). The integer unit, the adder and the multiplier each accept an independent instruction on consecutive cycles without a stall.
- R3: After a divide leaves decode in cycle t, the next divide cannot leave before cycle t+8. Instructions for the other units are not held by a busy divider.
- R4: An instruction of latency L that leaves decode in cycle t occupies the memory stage in cycle t+L+1. An instruction whose memory-stage cycle is already claimed stalls until that cycle is free.
- R5: A source register written by an instruction of latency L that left decode in cycle t can be read by an instruction leaving decode no earlier than cycle t+L. A reader directly after the integer unit therefore never stalls.
- R6: A write to a register with a pending write stalls until its own memory-stage cycle falls strictly after that of the pending write. The stall length depends on the older latency and on the distance between the two instructions.
- R7: A write to a register that an older, still-running instruction reads causes no stall.
- R8: A stalled instruction changes no tracking state. If it is withdrawn, a later instruction sees no reservation or pending write from it.
- R9: After reset nothing is in flight, and the first valid instruction leaves decode at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid_i | input | 1 | An instruction is present in decode |
| dec_unit_i | input | 2 | Execution unit code (see R2) |
| dec_src_a_i | input | REG_AW | First source register |
| dec_src_b_i | input | REG_AW | Second source register |
| dec_dst_i | input | REG_AW | Destination register |
| stall_o | output | 1 | Instruction must stay in decode this cycle |
| issue_o | output | 1 | Instruction leaves decode at this clock edge |

## Verification
The hardest situation to reach is one where several hazards overlap in a single held instruction. An example is an integer op that first collides in the memory stage with a multiplier result and then, one cycle later, with an adder result. The stall length in that case comes only from the ring, not from any register dependency. The stimulus reaches it by issuing a multiplier op and, after one stall, an adder op, then presenting an integer op on the next cycle so that its memory-stage cycle lands on each older result in turn. A second hard case is a write-after-write stall that depends on distance. The bench reaches it by inserting idle cycles between a divide and a later adder op to the same register, so that the countdown has partly run down when the writer arrives.

// File: rtl/fu_issue_pkg.sv
`timescale 1ns/1ps
package fu_issue_pkg;

    typedef enum logic [1:0] {
        UNIT_INT  = 2'd0,
        UNIT_FADD = 2'd1,
        UNIT_FMUL = 2'd2,
        UNIT_DIV  = 2'd3
    } unit_e;

    typedef enum logic {
        DV_IDLE = 1'b0,
        DV_RUN  = 1'b1
    } dv_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wb_slot_ring.sv
`timescale 1ns/1ps
// Future memory-stage occupancy. Bit j means the memory stage is taken
// j+1 cycles from now. The ring shifts down by one every cycle.
module wb_slot_ring #(
    parameter int DEPTH = 9,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             claim_i,
    input  logic [IDX_W-1:0] claim_idx_i,
    input  logic [IDX_W-1:0] probe_idx_i,
    output logic             probe_taken_o
);

    logic [DEPTH-1:0] slots_q;
    logic [DEPTH-1:0] slots_d;
    logic [DEPTH-1:0] claim_vec;

    always_comb begin
        claim_vec = '0;
        if (claim_i) begin
            claim_vec[claim_idx_i] = 1'b1;
        end
        slots_d = (slots_q | claim_vec) >> 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slots_q <= '0;
        end else begin
            slots_q <= slots_d;
        end
    end

    assign probe_taken_o = slots_q[probe_idx_i];

endmodule

// File: rtl/reg_pend_table.sv
`timescale 1ns/1ps
// One countdown per architectural register: the number of cycles until
// its pending result can be forwarded. Zero means nothing is outstanding.
module reg_pend_table #(
    parameter int NUM_REGS = 32,
    parameter int REG_AW   = 5,
    parameter int CNT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic [REG_AW-1:0] set_reg_i,
    input  logic [CNT_W-1:0]  set_val_i,
    input  logic [REG_AW-1:0] rd_a_i,
    input  logic [REG_AW-1:0] rd_b_i,
    input  logic [REG_AW-1:0] rd_d_i,
    output logic [CNT_W-1:0]  cnt_a_o,
    output logic [CNT_W-1:0]  cnt_b_o,
    output logic [CNT_W-1:0]  cnt_d_o
);

    logic [CNT_W-1:0] cnt_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (set_i && (set_reg_i == REG_AW'(g))) begin
                cnt_q[g] <= set_val_i;
            end else if (cnt_q[g] != '0) begin
                cnt_q[g] <= cnt_q[g] - CNT_W'(1);
            end
        end
    end

    assign cnt_a_o = cnt_q[rd_a_i];
    assign cnt_b_o = cnt_q[rd_b_i];
    assign cnt_d_o = cnt_q[rd_d_i];

endmodule

// File: rtl/div_occupancy.sv
`timescale 1ns/1ps
// Occupancy of the unpipelined divider as a two-state machine.
module div_occupancy
    import fu_issue_pkg::*;
#(
    parameter int LAT_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = (LAT_DIV > 1) ? $clog2(LAT_DIV) : 1;
    localparam logic [CW-1:0] RUN_LOAD = CW'((LAT_DIV > 1) ? LAT_DIV - 1 : 0);

    dv_state_e     state_q, state_d;
    logic [CW-1:0] left_q, left_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DV_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    // transitions: START (DV_IDLE -> DV_RUN), DONE (DV_RUN -> DV_IDLE)
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            DV_IDLE: begin
                if (start_i && (LAT_DIV > 1)) begin
                    state_d = DV_RUN;
                    left_d  = RUN_LOAD;
                end
            end
            DV_RUN: begin
                if (left_q <= CW'(1)) begin
                    state_d = DV_IDLE;
                    left_d  = '0;
                end else begin
                    left_d  = left_q - CW'(1);
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            DV_IDLE: busy_o = 1'b0;
            DV_RUN:  busy_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/fu_hazard_judge.sv
`timescale 1ns/1ps
// Combines the hazard conditions into the stall/issue decision.
module fu_hazard_judge #(
    parameter int LAT_W = 4
) (
    input  logic             valid_i,
    input  logic             div_req_i,
    input  logic             div_busy_i,
    input  logic             slot_taken_i,
    input  logic [LAT_W-1:0] pend_a_i,
    input  logic [LAT_W-1:0] pend_b_i,
    input  logic [LAT_W-1:0] pend_d_i,
    input  logic [LAT_W-1:0] lat_i,
    output logic             stall_o,
    output logic             issue_o
);

    logic unit_hit;
    logic raw_hit;
    logic waw_hit;

    always_comb begin
        unit_hit = div_req_i && div_busy_i;
        raw_hit  = (pend_a_i != '0) || (pend_b_i != '0);
        // later write must land strictly after the pending one
        waw_hit  = (pend_d_i >= lat_i);
        stall_o  = valid_i && (unit_hit || slot_taken_i || raw_hit || waw_hit);
        issue_o  = valid_i && !stall_o;
    end

endmodule

// File: rtl/fu_issue_gate.sv
`timescale 1ns/1ps
module fu_issue_gate
    import fu_issue_pkg::*;
#(
    parameter int REG_AW   = 5,
    parameter int LAT_INT  = 1,
    parameter int LAT_FADD = 3,
    parameter int LAT_FMUL = 4,
    parameter int LAT_DIV  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid_i,
    input  logic [1:0]        dec_unit_i,
    input  logic [REG_AW-1:0] dec_src_a_i,
    input  logic [REG_AW-1:0] dec_src_b_i,
    input  logic [REG_AW-1:0] dec_dst_i,
    output logic              stall_o,
    output logic              issue_o
);

    localparam int NUM_REGS = 1 << REG_AW;
    localparam int MAX_LAT  = max2(max2(LAT_INT, LAT_FADD), max2(LAT_FMUL, LAT_DIV));
    localparam int LAT_W    = $clog2(MAX_LAT + 1);
    localparam int RING_D   = MAX_LAT + 1;

    unit_e            unit;
    logic [LAT_W-1:0] lat_sel;
    logic [LAT_W-1:0] pend_load;
    logic [LAT_W-1:0] pend_a, pend_b, pend_d;
    logic             slot_taken;
    logic             div_busy;
    logic             div_req;
    logic             stall_w, issue_w;

    assign unit = unit_e'(dec_unit_i);

    always_comb begin
        unique case (unit)
            UNIT_INT:  lat_sel = LAT_W'(LAT_INT);
            UNIT_FADD: lat_sel = LAT_W'(LAT_FADD);
            UNIT_FMUL: lat_sel = LAT_W'(LAT_FMUL);
            UNIT_DIV:  lat_sel = LAT_W'(LAT_DIV);
        endcase
    end

    assign pend_load = lat_sel - LAT_W'(1);
    assign div_req   = (unit == UNIT_DIV);

    wb_slot_ring #(
        .DEPTH (RING_D),
        .IDX_W (LAT_W)
    ) u_ring (
        .clk           (clk),
        .rst_n         (rst_n),
        .claim_i       (issue_w),
        .claim_idx_i   (lat_sel),
        .probe_idx_i   (lat_sel),
        .probe_taken_o (slot_taken)
    );

    reg_pend_table #(
        .NUM_REGS (NUM_REGS),
        .REG_AW   (REG_AW),
        .CNT_W    (LAT_W)
    ) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (issue_w),
        .set_reg_i (dec_dst_i),
        .set_val_i (pend_load),
        .rd_a_i    (dec_src_a_i),
        .rd_b_i    (dec_src_b_i),
        .rd_d_i    (dec_dst_i),
        .cnt_a_o   (pend_a),
        .cnt_b_o   (pend_b),
        .cnt_d_o   (pend_d)
    );

    div_occupancy #(
        .LAT_DIV (LAT_DIV)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (issue_w && div_req),
        .busy_o  (div_busy)
    );

    fu_hazard_judge #(
        .LAT_W (LAT_W)
    ) u_judge (
        .valid_i      (dec_valid_i),
        .div_req_i    (div_req),
        .div_busy_i   (div_busy),
        .slot_taken_i (slot_taken),
        .pend_a_i     (pend_a),
        .pend_b_i     (pend_b),
        .pend_d_i     (pend_d),
        .lat_i        (lat_sel),
        .stall_o      (stall_w),
        .issue_o      (issue_w)
    );

    assign stall_o = stall_w;
    assign issue_o = issue_w;

endmodule

// File: rtl/fu_issue_gate_chk.sv
`timescale 1ns/1ps
module fu_issue_gate_chk
    import fu_issue_pkg::*;
#(
    parameter int REG_AW   = 5,
    parameter int LAT_INT  = 1,
    parameter int LAT_FADD = 3,
    parameter int LAT_FMUL = 4,
    parameter int LAT_DIV  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dec_valid_i,
    input logic [1:0]        dec_unit_i,
    input logic [REG_AW-1:0] dec_src_a_i,
    input logic [REG_AW-1:0] dec_src_b_i,
    input logic [REG_AW-1:0] dec_dst_i,
    input logic              stall_o,
    input logic              issue_o
);

    function automatic int lat_of(input logic [1:0] u);
        case (u)
            2'd0:    return LAT_INT;
            2'd1:    return LAT_FADD;
            2'd2:    return LAT_FMUL;
            default: return LAT_DIV;
        endcase
    endfunction

    int                since_div;
    logic              prev_mul_iss;
    logic              prev_long_iss;
    logic [REG_AW-1:0] prev_dst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_div     <= LAT_DIV;
            prev_mul_iss  <= 1'b0;
            prev_long_iss <= 1'b0;
            prev_dst      <= '0;
        end else begin
            if (issue_o && dec_unit_i == 2'd3) since_div <= 1;
            else if (since_div < LAT_DIV)      since_div <= since_div + 1;
            prev_mul_iss  <= issue_o && dec_unit_i == 2'd2;
            prev_long_iss <= issue_o && lat_of(dec_unit_i) > 1;
            prev_dst      <= dec_dst_i;
        end
    end

    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall_o && issue_o));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |-> (!stall_o && !issue_o));

    a_r1_decided: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |-> (stall_o || issue_o));

    a_r3_div_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && dec_unit_i == 2'd3) |-> (since_div >= LAT_DIV));

    a_r4_mem_collision: assert property (@(posedge clk) disable iff (!rst_n)
        !((LAT_FMUL == LAT_FADD + 1) && issue_o && dec_unit_i == 2'd1 && prev_mul_iss));

    a_r5_raw_next: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && prev_long_iss) |-> (dec_src_a_i != prev_dst && dec_src_b_i != prev_dst));

    a_r6_waw_next: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && prev_long_iss && lat_of(dec_unit_i) == 1) |-> (dec_dst_i != prev_dst));

endmodule

bind fu_issue_gate fu_issue_gate_chk #(
    .REG_AW   (REG_AW),
    .LAT_INT  (LAT_INT),
    .LAT_FADD (LAT_FADD),
    .LAT_FMUL (LAT_FMUL),
    .LAT_DIV  (LAT_DIV)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_valid_i (dec_valid_i),
    .dec_unit_i  (dec_unit_i),
    .dec_src_a_i (dec_src_a_i),
    .dec_src_b_i (dec_src_b_i),
    .dec_dst_i   (dec_dst_i),
    .stall_o     (stall_o),
    .issue_o     (issue_o)
);

// File: tb/sim_fu_issue_gate.sv
`timescale 1ns/1ps
module sim_fu_issue_gate;

    localparam logic [1:0] U_INT = 2'd0, U_ADD = 2'd1, U_MUL = 2'd2, U_DIV = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_valid_i = 1'b0;
    logic [1:0] dec_unit_i = 2'd0;
    logic [4:0] dec_src_a_i = '0, dec_src_b_i = '0, dec_dst_i = '0;
    logic       stall_o, issue_o;

    int n_checks = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    fu_issue_gate u0 (
        .clk(clk), .rst_n(rst_n), .dec_valid_i(dec_valid_i), .dec_unit_i(dec_unit_i),
        .dec_src_a_i(dec_src_a_i), .dec_src_b_i(dec_src_b_i), .dec_dst_i(dec_dst_i),
        .stall_o(stall_o), .issue_o(issue_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // drive at the falling edge, settle, then outputs may be sampled
    task automatic present(input bit v, input logic [1:0] u, input int a, input int b, input int d);
        @(negedge clk);
        dec_valid_i = v;
        dec_unit_i  = u;
        dec_src_a_i = 5'(a);
        dec_src_b_i = 5'(b);
        dec_dst_i   = 5'(d);
        #2;
    endtask

    // hold one instruction in decode until it leaves; compare stall count
    task automatic try_issue(input logic [1:0] u, input int a, input int b, input int d,
                             input int exp, input string tag);
        int  n = 0;
        bit  done = 0;
        while (!done && n <= 20) begin
            present(1'b1, u, a, b, d);
            if (issue_o) done = 1;
            else begin
                if (!stall_o) chk(1'b0, "R1", "valid without stall or issue", 0, 1);
                n++;
            end
        end
        chk(done && n == exp, tag, "stall cycles", n, exp);
    endtask

    task automatic bubble(input int n);
        bit quiet = 1;
        for (int i = 0; i < n; i++) begin
            present(1'b0, U_INT, 0, 0, 0);
            if (stall_o || issue_o) quiet = 0;
        end
        chk(quiet, "R1", "idle decode quiet", int'(quiet), 1);
    endtask

    task automatic t_reset;
        present(1'b0, U_DIV, 1, 2, 3);
        chk(!stall_o && !issue_o, "R9", "outputs idle after reset", int'(stall_o), 0);
        try_issue(U_INT, 2, 3, 1, 0, "R9");
        bubble(12);
    endtask

    task automatic t_pipelined;
        try_issue(U_ADD, 2, 3, 1, 0, "R2");
        try_issue(U_ADD, 5, 6, 4, 0, "R2");
        try_issue(U_MUL, 2, 3, 7, 0, "R2");
        try_issue(U_MUL, 5, 6, 8, 0, "R2");
        try_issue(U_INT, 5, 6, 9, 0, "R2");
        bubble(12);
    endtask

    task automatic t_divider;
        try_issue(U_DIV, 2, 3, 1, 0, "R3");
        try_issue(U_INT, 5, 6, 4, 0, "R3");
        present(1'b0, U_DIV, 8, 9, 10);
        chk(!stall_o && !issue_o, "R1", "invalid divide not stalled", int'(stall_o), 0);
        try_issue(U_DIV, 8, 9, 7, 5, "R3");
        bubble(12);
    endtask

    task automatic t_slot;
        try_issue(U_MUL, 10, 11, 1, 0, "R4");
        try_issue(U_ADD, 3, 4, 2, 1, "R4");
        try_issue(U_INT, 6, 8, 5, 2, "R4");
        bubble(12);
    endtask

    task automatic t_raw;
        try_issue(U_MUL, 1, 2, 7, 0, "R5");
        try_issue(U_INT, 7, 4, 3, 3, "R5");
        bubble(12);
        try_issue(U_ADD, 1, 2, 8, 0, "R5");
        try_issue(U_ADD, 1, 8, 9, 2, "R5");
        bubble(12);
        try_issue(U_INT, 1, 2, 10, 0, "R5");
        try_issue(U_INT, 10, 10, 11, 0, "R5");
        bubble(12);
    endtask

    task automatic t_waw;
        try_issue(U_MUL, 1, 2, 12, 0, "R6");
        try_issue(U_INT, 3, 4, 12, 3, "R6");
        bubble(12);
        try_issue(U_ADD, 1, 2, 13, 0, "R6");
        try_issue(U_MUL, 3, 4, 13, 0, "R6");
        bubble(12);
        try_issue(U_DIV, 1, 2, 14, 0, "R6");
        bubble(3);
        try_issue(U_ADD, 3, 4, 14, 2, "R6");
        bubble(12);
    endtask

    task automatic t_war;
        try_issue(U_MUL, 5, 6, 1, 0, "R7");
        try_issue(U_INT, 2, 3, 5, 0, "R7");
        bubble(12);
    endtask

    task automatic t_withdraw;
        try_issue(U_MUL, 1, 2, 3, 0, "R8");
        present(1'b1, U_ADD, 3, 5, 4);
        chk(stall_o && !issue_o, "R8", "dependent add held", int'(issue_o), 0);
        present(1'b1, U_ADD, 3, 5, 4);
        chk(stall_o && !issue_o, "R8", "dependent add still held", int'(issue_o), 0);
        bubble(1);
        try_issue(U_INT, 4, 4, 6, 0, "R8");
        bubble(12);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pipelined();
        t_divider();
        t_slot();
        t_raw();
        t_waw();
        t_war();
        t_withdraw();
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL R1 watchdog expired: actual %0d expected %0d", 5000, 0);
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule